// File: doc/BRIEF.md
# Rotate-and-Mask Bit-Field Unit

This unit is the shift datapath of a packet-header processor. It takes one 32-bit instruction word and two source operand values: a data operand and a control operand. From these it produces one 32-bit result. The opcode and function fields of the instruction select one of nine operations:

- three fixed-amount shifts;
- three variable-amount shifts;
- two shift-then-mask operations, whose mask width comes from the control operand;
- a rotate-and-mask operation, which cuts an arbitrary bit field out of a word in one step.

The result is captured in a single output register, so it appears one clock after the inputs. Register-file access and instruction fetch sit outside the block. The caller places the data operand on `rt_val` and the control operand on `rs_val`.

Top module: `bitfield_shifter`

## Requirements
- R1: An active-low `rst_n` clears `result` to zero asynchronously. Otherwise `result` shows, one rising clock edge later, the value computed from the inputs present at that edge.
- R2: With opcode `insn[31:26]` = 0, function `insn[5:0]` 0, 2 and 3 select the fixed shifts. These are, in order, shift left, shift right logical and shift right arithmetic of `rt_val`, by the amount in `insn[10:6]`. The all-zero instruction word therefore returns `rt_val` unchanged.
- R3: With opcode 0, function 4, 6 and 7 select the variable shifts: left, right logical and right arithmetic. The amount is `rs_val[4:0]`, and `rs_val[31:5]` has no effect.
- R4: Arithmetic right shifts fill the vacated upper bits with copies of `rt_val[31]`. Logical right shifts fill them with zeros.
- R5: Opcode 0 with function 1 returns `(rt_val << insn[10:6]) & (32'hFFFFFFFF >> rs_val[4:0])`.
- R6: Opcode 0 with function 5 returns `(rt_val >> insn[10:6]) & (32'hFFFFFFFF << rs_val[4:0])`, where the right shift is logical.
- R7: Opcode 39 with `insn[5]` = 0 selects rotate-and-mask. It rotates `rt_val` right by `insn[10:6]`, then ANDs the rotated value with `32'hFFFFFFFF >> insn[4:0]` and with `32'hFFFFFFFF << insn[25:21]`.
- R8: The following encodings produce a zero result: opcode 39 with `insn[5]` = 1, any opcode other than 0 and 39, and opcode 0 with a function value above 7.
- R9: A mask width of 0, from either the control operand or an instruction field, leaves the mask all ones. A rotate amount of 0 returns `rt_val` unrotated before masking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| insn | input | 32 | Instruction word: opcode, function, shift amount and mask fields |
| rt_val | input | 32 | Data operand that is shifted or rotated |
| rs_val | input | 32 | Control operand: variable shift amount or mask width (low 5 bits) |
| result | output | 32 | Registered result |

## Verification
The bound checker watches the following properties on every cycle:

- the sign fill of arithmetic shifts;
- the zero fill of logical shifts;
- that no bit survives outside the register-sized mask of either shift-then-mask operation;
- the identity case of a rotate-and-mask whose rotate amount and both mask widths are zero;
- the zero result of unrecognised encodings.

The bench must show the exact bit values of every operation. It sweeps every shift amount, every pair of mask widths and every rotate amount against an independent bit-by-bit model. It sets the upper control-operand bits so that they would corrupt the variable amounts if they were used. It also covers the asynchronous clear in the middle of a run.

// File: rtl/bitfield_shifter.sv
module bitfield_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  insn,
  input  logic [W-1:0] rt_val,
  input  logic [W-1:0] rs_val,
  output logic [W-1:0] result
);
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_ROTMASK = 6'd39;
  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SLMV = 6'd1;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_SRA  = 6'd3;
  localparam logic [5:0] FN_SLLV = 6'd4;
  localparam logic [5:0] FN_SRMV = 6'd5;
  localparam logic [5:0] FN_SRLV = 6'd6;
  localparam logic [5:0] FN_SRAV = 6'd7;

  wire [5:0]    opc    = insn[31:26];
  wire [5:0]    fn     = insn[5:0];
  wire [SW-1:0] fix_sh = insn[6 +: SW];
  wire [SW-1:0] var_sh = rs_val[SW-1:0];
  wire [SW-1:0] lw     = insn[SW-1:0];
  wire [SW-1:0] rw     = insn[21 +: SW];

  logic [2*W-1:0] dbl_rot;
  logic [W-1:0]   rot_v, rotmask_v, slmv_v, srmv_v, next_v;

  assign dbl_rot   = {rt_val, rt_val} >> fix_sh;
  assign rot_v     = dbl_rot[W-1:0];
  assign rotmask_v = rot_v & (ONES >> lw) & (ONES << rw);
  assign slmv_v    = (rt_val << fix_sh) & (ONES >> var_sh);
  assign srmv_v    = (rt_val >> fix_sh) & (ONES << var_sh);

  always_comb begin
    next_v = '0;
    if (opc == OPC_SPECIAL) begin
      case (fn)
        FN_SLL:  next_v = rt_val << fix_sh;
        FN_SLMV: next_v = slmv_v;
        FN_SRL:  next_v = rt_val >> fix_sh;
        FN_SRA:  next_v = $signed(rt_val) >>> fix_sh;
        FN_SLLV: next_v = rt_val << var_sh;
        FN_SRMV: next_v = srmv_v;
        FN_SRLV: next_v = rt_val >> var_sh;
        FN_SRAV: next_v = $signed(rt_val) >>> var_sh;
        default: next_v = '0;
      endcase
    end else if (opc == OPC_ROTMASK && !insn[5]) begin
      next_v = rotmask_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= next_v;
  end

  logic unused_bits;
  assign unused_bits = ^{insn[20:11], insn[25:21], rs_val[W-1:SW]};
endmodule

// File: rtl/bitfield_shifter_chk.sv
module bitfield_shifter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [31:0]  insn,
  input logic [W-1:0] rt_val,
  input logic [W-1:0] rs_val,
  input logic [W-1:0] result
);
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] ONES = '1;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  wire spc      = insn[31:26] == 6'd0;
  wire is_sra   = spc && (insn[5:0] == 6'd3 || insn[5:0] == 6'd7);
  wire is_srl   = spc && (insn[5:0] == 6'd2 || insn[5:0] == 6'd6);
  wire srl_amt  = (insn[5:0] == 6'd2) ? (insn[10:6] != 5'd0) : (rs_val[SW-1:0] != '0);
  wire is_slmv  = spc && insn[5:0] == 6'd1;
  wire is_srmv  = spc && insn[5:0] == 6'd5;
  wire rm_ident = insn == {6'd39, 26'd0};
  wire legal    = (spc && insn[5:0] < 6'd8) || (insn[31:26] == 6'd39 && !insn[5]);

  a_r4_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(is_sra && rt_val[W-1]) |-> result[W-1]);

  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(is_srl && srl_amt) |-> !result[W-1]);

  a_r5_slmv_mask: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(is_slmv) |-> (result & ~(ONES >> $past(rs_val[SW-1:0]))) == '0);

  a_r6_srmv_mask: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(is_srmv) |-> (result & ~(ONES << $past(rs_val[SW-1:0]))) == '0);

  a_r9_rot_identity: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(rm_ident) |-> result == $past(rt_val));

  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!legal) |-> result == '0);
endmodule

bind bitfield_shifter bitfield_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn(insn), .rt_val(rt_val), .rs_val(rs_val), .result(result)
);

// File: tb/tb_bitfield_shifter.sv
module tb_bitfield_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0, rt_val = '0, rs_val = '0;
  logic [31:0] result;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  bitfield_shifter dut (.clk(clk), .rst_n(rst_n), .insn(insn), .rt_val(rt_val),
                        .rs_val(rs_val), .result(result));

  localparam logic [127:0] VEC [12] = '{
    {32'h0000_0100, 32'h0000_00F1, 32'h0, 32'h0000_0F10},
    {32'h0000_0203, 32'h8000_1200, 32'h0, 32'hFF80_0012},
    {32'h0000_0202, 32'h8000_1200, 32'h0, 32'h0080_0012},
    {32'h0000_0004, 32'h0000_0001, 32'hFFFF_FFE3, 32'h0000_0008},
    {32'h0000_0007, 32'hF000_0000, 32'h0000_0021, 32'hF800_0000},
    {32'h0000_0101, 32'h0000_ABCD, 32'h0000_0010, 32'h0000_BCD0},
    {32'h0000_0105, 32'hABCD_0000, 32'h0000_0008, 32'h0ABC_D000},
    {32'h9D00_0408, 32'h1234_5678, 32'h0, 32'h0078_1200},
    {32'h9D00_0428, 32'h1234_5678, 32'h0, 32'h0000_0000},
    {32'h0400_0000, 32'hFFFF_FFFF, 32'h0, 32'h0000_0000},
    {32'h0000_0008, 32'hFFFF_FFFF, 32'h0, 32'h0000_0000},
    {32'h0000_0000, 32'h1357_9BDF, 32'h0, 32'h1357_9BDF}
  };
  localparam string VTAG [12] = '{"R2", "R4", "R4", "R3", "R4", "R5", "R6", "R7",
                                  "R8", "R8", "R8", "R2"};

  function automatic logic [31:0] f_shl(logic [31:0] v, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) if (i >= n) r[i] = v[i-n];
    return r;
  endfunction
  function automatic logic [31:0] f_shr(logic [31:0] v, int n, logic fill);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : fill;
    return r;
  endfunction
  function automatic logic [31:0] f_rot(logic [31:0] v, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = v[(i+n)%32];
    return r;
  endfunction
  function automatic logic [31:0] f_keep_low(int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = (i < 32 - n);
    return r;
  endfunction
  function automatic logic [31:0] f_keep_high(int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = (i >= n);
    return r;
  endfunction

  function automatic logic [31:0] model(logic [31:0] iw, logic [31:0] a, logic [31:0] b);
    int sh = int'(iw[10:6]);
    int vs = int'(b[4:0]);
    if (iw[31:26] == 6'd0) begin
      case (iw[5:0])
        6'd0: return f_shl(a, sh);
        6'd1: return f_shl(a, sh) & f_keep_low(vs);
        6'd2: return f_shr(a, sh, 1'b0);
        6'd3: return f_shr(a, sh, a[31]);
        6'd4: return f_shl(a, vs);
        6'd5: return f_shr(a, sh, 1'b0) & f_keep_high(vs);
        6'd6: return f_shr(a, vs, 1'b0);
        6'd7: return f_shr(a, vs, a[31]);
        default: return 32'h0;
      endcase
    end
    if (iw[31:26] == 6'd39 && !iw[5])
      return f_rot(a, sh) & f_keep_low(int'(iw[4:0])) & f_keep_high(int'(iw[25:21]));
    return 32'h0;
  endfunction

  function automatic logic [31:0] mk_sp(int fn, int sh);
    return {6'd0, 5'd0, 5'd0, 5'd0, 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] mk_rm(int mr, int sh, int ml);
    return {6'd39, 5'(mr), 5'd0, 5'd0, 5'(sh), 1'b0, 5'(ml)};
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s insn=%h rt=%h rs=%h actual=%h expected=%h",
               tag, insn, rt_val, rs_val, result, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] iw, logic [31:0] a, logic [31:0] b,
                     logic [31:0] exp);
    insn = iw; rt_val = a; rs_val = b;
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [2];
    pats[0] = 32'h8765_4321;
    pats[1] = 32'h7F00_00FF;
    insn = 32'h0000_0000; rt_val = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1", 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < 12; k++)
      run(VTAG[k], VEC[k][127:96], VEC[k][95:64], VEC[k][63:32], VEC[k][31:0]);

    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 32; s++) begin
        logic [31:0] b = 32'hFFFF_FFE0 | 32'(s);
        run("R2", mk_sp(0, s), pats[p], 32'h0, model(mk_sp(0, s), pats[p], 32'h0));
        run("R4", mk_sp(2, s), pats[p], 32'h0, model(mk_sp(2, s), pats[p], 32'h0));
        run("R4", mk_sp(3, s), pats[p], 32'h0, model(mk_sp(3, s), pats[p], 32'h0));
        run("R3", mk_sp(4, 0), pats[p], b, model(mk_sp(4, 0), pats[p], b));
        run("R3", mk_sp(6, 0), pats[p], b, model(mk_sp(6, 0), pats[p], b));
        run("R3", mk_sp(7, 0), pats[p], b, model(mk_sp(7, 0), pats[p], b));
      end

    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 32; w++) begin
        logic [31:0] b = 32'hABCD_E000 | 32'(w);
        run(w == 0 ? "R9" : "R5", mk_sp(1, s), 32'hC3A5_5A3C, b,
            model(mk_sp(1, s), 32'hC3A5_5A3C, b));
        run(w == 0 ? "R9" : "R6", mk_sp(5, s), 32'hC3A5_5A3C, b,
            model(mk_sp(5, s), 32'hC3A5_5A3C, b));
      end

    for (int mr = 0; mr < 32; mr++)
      for (int ml = 0; ml < 32; ml++) begin
        int s = (mr * 7 + ml) % 32;
        run((mr == 0 || ml == 0 || s == 0) ? "R9" : "R7", mk_rm(mr, s, ml),
            32'h9E37_79B9, 32'h0, model(mk_rm(mr, s, ml), 32'h9E37_79B9, 32'h0));
      end

    run("R9", mk_rm(0, 0, 0), 32'hDEAD_BEEF, 32'h0, 32'hDEAD_BEEF);
    run("R8", mk_rm(0, 0, 0) | 32'h20, 32'hDEAD_BEEF, 32'h0, 32'h0);
    run("R8", {6'd39, 26'h3FF_FFDF} | 32'h20, 32'hDEAD_BEEF, 32'h0, 32'h0);
    run("R8", mk_sp(9, 3), 32'hDEAD_BEEF, 32'h0, 32'h0);

    run("R1", mk_sp(0, 0), 32'h0000_FFFF, 32'h0, 32'h0000_FFFF);
    #2 rst_n = 1'b0;
    #1 check("R1", 32'h0);
    @(negedge clk);
    check("R1", 32'h0);
    rst_n = 1'b1;
    run("R1", mk_sp(2, 4), 32'h0000_FFFF, 32'h0, 32'h0000_0FFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule